// File: doc/BRIEF.md
# Serial Port Interrupt Status Unit

This block builds the interrupt logic for a synchronous serial port controller. It watches the fill levels of the receive and transmit FIFOs, a strobe that marks the end of each received frame, and a strobe for each read of the receive FIFO. From these it derives four interrupt sources: receive overrun, receive idle timeout, receive FIFO at least half full, and transmit FIFO at least half empty.

Overrun and timeout are sticky flags, and software clears them by writing ones. The two level sources follow the FIFO levels directly. They go away only when FIFO traffic moves the level, or when software masks them. The timeout is measured in serial bit periods. The bit period is derived from the same prescaler and clock-rate settings that the shift engine uses, so the timeout lasts 32 bit periods at whatever bit rate is programmed.

A small register port gives access to the enable mask, the raw and masked status, and a write-one-to-clear register. A single registered interrupt line combines all enabled sources.

Top module: `sspirq_top`

## Requirements
- R1: After reset the enable mask is 0, both sticky flags are 0, the masked status reads 0 and `irq` is 0.
- R2: The overrun flag (status bit 0) sets on the clock edge where `frame_done` is high and `rx_level` equals the FIFO depth (8). It stays set after `frame_done` drops. A frame arriving at any lower level does not set it.
- R3: While `rx_level` is non-zero and there is neither a `rx_pop` nor a `frame_done`, the timeout flag (status bit 1) sets exactly 32 × P × (S+1) clock edges after the last restart. P is `prescale` (a value of 0 counts as 1) and S is `scr`.
- R4: A `rx_pop` or a `frame_done` restarts the timeout count. While `rx_level` is 0 the count is held at zero, and the timeout then expires on the 32·P·(S+1)-th edge on which the FIFO is non-empty.
- R5: Status bit 2 is 1 when `rx_level` ≥ 4. Status bit 3 is 1 when `tx_level` ≤ 4. Both follow the levels with no storage.
- R6: The masked status equals the raw status ANDed with the mask. The mask is written at address 0, bits 3:0, and uses the same bit order as the status.
- R7: A write to address 3 clears the overrun flag when data bit 0 is 1, and clears the timeout flag when data bit 1 is 1. Zero bits have no effect, bits 2 and 3 have no effect on the level sources, and address 3 reads back as 0.
- R8: When a set condition and a clearing write for the same flag fall on one edge, the flag ends up set.
- R9: `irq` is the OR of the four masked status bits, delayed by one register stage.
- R10: The read map is address 0 for the mask, 1 for raw status, 2 for masked status and 3 for zero. Read data bits 31:4 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_level | input | 4 | Receive FIFO entry count (0..8) |
| tx_level | input | 4 | Transmit FIFO entry count (0..8) |
| frame_done | input | 1 | One-cycle strobe: a frame finished arriving |
| rx_pop | input | 1 | One-cycle strobe: receive FIFO was read |
| prescale | input | 8 | Clock prescaler divisor |
| scr | input | 8 | Serial clock rate factor (bit time multiplier minus one) |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on address) |
| irq | output | 1 | Combined registered interrupt |

## Verification
The bench sweeps every pair of receive and transmit levels against all sixteen masks. This catches half-way thresholds that are off by one, which would mark a 3-entry receive FIFO as half full or a 5-entry transmit FIFO as half empty. It also catches a mask applied to the wrong bit. The timeout is timed edge-exact over a grid of prescaler and rate values, including a prescaler of zero. A timer off by one period, or one that ignored the multiplier, would fire one edge early or late. Separate runs check that a read restarts the count and that an empty FIFO holds it, since a timer that kept counting would fire too soon. Overrun is checked at full versus nearly full, and against zero-bit and level-bit clear writes and a same-edge set and clear. A design where the clear wins, or where the clear register touches the level sources, fails those checks.

// File: rtl/sspirq_pkg.sv
// Shared constants for the serial port interrupt status unit.
// Assumes: four sources with fixed bit positions, used by software.
package sspirq_pkg;
    localparam int SRC_N   = 4;
    localparam int SRC_OVR = 0;
    localparam int SRC_TO  = 1;
    localparam int SRC_RXH = 2;
    localparam int SRC_TXH = 3;

    typedef enum logic [1:0] {
        REG_MASK = 2'd0,
        REG_RAW  = 2'd1,
        REG_MIS  = 2'd2,
        REG_CLR  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/ssp_level_cmp.sv
// Compares the FIFO fill counts against the half-way mark and the ends.
// Assumes: DEPTH is even and the counts never exceed DEPTH.
module ssp_level_cmp #(
    parameter int DEPTH = 8,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_level,
    output logic             rx_half,
    output logic             tx_half,
    output logic             rx_empty,
    output logic             rx_full
);
    localparam logic [LVL_W-1:0] HALF = LVL_W'(DEPTH / 2);
    localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

    // Threshold and end-of-range decode of the two fill counts.
    always_comb begin
        rx_half  = (rx_level >= HALF);
        tx_half  = (tx_level <= HALF);
        rx_empty = (rx_level == '0);
        rx_full  = (rx_level == FULL);
    end
endmodule

// File: rtl/ssp_idle_timer.sv
// Counts serial bit periods while the receive FIFO holds data and pulses
// expire once the programmed number of bit periods has gone by.
// Assumes: a prescale value of 0 behaves as 1; after expiring the timer
// parks until the next restart or empty FIFO.
module ssp_idle_timer #(
    parameter int PRE_W = 8,
    parameter int SCR_W = 8,
    parameter int BITS  = 32,
    parameter int BIT_W = $clog2(BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [PRE_W-1:0] prescale,
    input  logic [SCR_W-1:0] scr,
    output logic             expire
);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BITS - 1);
    localparam logic [BIT_W-1:0] BIT_DONE = BIT_W'(BITS);

    logic [PRE_W-1:0] pre_q;
    logic [SCR_W-1:0] scr_q;
    logic [BIT_W-1:0] bit_q;
    logic             pre_last, scr_last, spent;

    // End-of-period decode for each counter stage.
    always_comb begin
        pre_last = ({1'b0, pre_q} + 1'b1) >= {1'b0, prescale};
        scr_last = (scr_q >= scr);
        spent    = (bit_q == BIT_DONE);
        expire   = run && !restart && !spent && pre_last && scr_last
                   && (bit_q == BIT_LAST);
    end

    // Prescale, rate and bit-period counters; cleared on restart or empty.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) begin
            pre_q <= '0;
            scr_q <= '0;
            bit_q <= '0;
        end else if (!spent) begin
            if (pre_last) begin
                pre_q <= '0;
                if (scr_last) begin
                    scr_q <= '0;
                    bit_q <= bit_q + 1'b1;
                end else begin
                    scr_q <= scr_q + 1'b1;
                end
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    AST_TMR_HOLD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (bit_q == '0 && pre_q == '0 && scr_q == '0)); // R4
    AST_TMR_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire); // R3
endmodule

// File: rtl/ssp_status_regs.sv
// Holds the enable mask and the two sticky flags, and forms raw and
// masked status. Assumes set conditions are single-cycle events.
module ssp_status_regs
    import sspirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ovr_set,
    input  logic             to_set,
    input  logic             rx_half,
    input  logic             tx_half,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [SRC_N-1:0] wbits,
    output logic [SRC_N-1:0] mask,
    output logic [SRC_N-1:0] raw,
    output logic [SRC_N-1:0] masked
);
    logic ovr_q, to_q;
    logic clr_hit, mask_hit;

    // Register-port write decode.
    always_comb begin
        clr_hit  = reg_wr && (reg_sel_e'(reg_addr) == REG_CLR);
        mask_hit = reg_wr && (reg_sel_e'(reg_addr) == REG_MASK);
    end

    // Enable mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)        mask <= '0;
        else if (mask_hit) mask <= wbits;
    end

    // Sticky overrun flag: set dominates write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                         ovr_q <= 1'b0;
        else if (ovr_set)                   ovr_q <= 1'b1;
        else if (clr_hit && wbits[SRC_OVR]) ovr_q <= 1'b0;
    end

    // Sticky timeout flag: set dominates write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                        to_q <= 1'b0;
        else if (to_set)                   to_q <= 1'b1;
        else if (clr_hit && wbits[SRC_TO]) to_q <= 1'b0;
    end

    // Raw status assembly and enable masking.
    always_comb begin
        raw          = '0;
        raw[SRC_OVR] = ovr_q;
        raw[SRC_TO]  = to_q;
        raw[SRC_RXH] = rx_half;
        raw[SRC_TXH] = tx_half;
        masked       = raw & mask;
    end

    AST_OVR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_set |=> ovr_q); // R2
    AST_OVR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && wbits[SRC_OVR] && !ovr_set) |=> !ovr_q); // R7
    AST_TO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && wbits[SRC_TO] && !to_set) |=> !to_q); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && to_set) |=> to_q); // R8
    AST_NO_CLR_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr_set && !ovr_q) |=> !ovr_q); // R2
endmodule

// File: rtl/sspirq_top.sv
// Interrupt status unit for a synchronous serial port: level compare,
// idle timeout, sticky flags, register read mux and combined interrupt.
// Assumes: level inputs are the current FIFO counts; strobes last one cycle.
module sspirq_top
    import sspirq_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int LVL_W   = $clog2(DEPTH + 1),
    parameter int PRE_W   = 8,
    parameter int SCR_W   = 8,
    parameter int TO_BITS = 32,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic              frame_done,
    input  logic              rx_pop,
    input  logic [PRE_W-1:0]  prescale,
    input  logic [SCR_W-1:0]  scr,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    logic             rx_half, tx_half, rx_empty, rx_full;
    logic             to_expire, ovr_set, restart;
    logic [SRC_N-1:0] mask, raw, masked;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:SRC_N];

    ssp_level_cmp #(.DEPTH(DEPTH), .LVL_W(LVL_W)) i_lvl (
        .rx_level (rx_level),
        .tx_level (tx_level),
        .rx_half  (rx_half),
        .tx_half  (tx_half),
        .rx_empty (rx_empty),
        .rx_full  (rx_full)
    );

    // Event decode for the timer and overrun flag.
    always_comb begin
        restart = rx_pop || frame_done;
        ovr_set = frame_done && rx_full;
    end

    ssp_idle_timer #(.PRE_W(PRE_W), .SCR_W(SCR_W), .BITS(TO_BITS)) i_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (!rx_empty),
        .restart  (restart),
        .prescale (prescale),
        .scr      (scr),
        .expire   (to_expire)
    );

    ssp_status_regs i_sts (
        .clk      (clk),
        .rst_n    (rst_n),
        .ovr_set  (ovr_set),
        .to_set   (to_expire),
        .rx_half  (rx_half),
        .tx_half  (tx_half),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .wbits    (reg_wdata[SRC_N-1:0]),
        .mask     (mask),
        .raw      (raw),
        .masked   (masked)
    );

    // Register read mux; upper bits and the clear register read as zero.
    always_comb begin
        reg_rdata = '0;
        case (reg_sel_e'(reg_addr))
            REG_MASK: reg_rdata[SRC_N-1:0] = mask;
            REG_RAW:  reg_rdata[SRC_N-1:0] = raw;
            REG_MIS:  reg_rdata[SRC_N-1:0] = masked;
            default:  reg_rdata = '0;
        endcase
    end

    // Combined interrupt output register.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |masked;
    end

    AST_IRQ_MASKED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |=> !irq); // R9
    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (|masked) |=> irq); // R9
    AST_TO_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw[SRC_TO]) |-> $past(rx_level != '0)); // R3
endmodule

// File: tb/test_sspirq_top.sv
// Self-checking bench: level/mask sweep, timeout timing grid, overrun,
// clear and interrupt checks.
module test_sspirq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rx_level = '0, tx_level = '0;
    logic        frame_done = 1'b0, rx_pop = 1'b0;
    logic [7:0]  prescale = 8'd255, scr = 8'd255;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    int          total = 0, bad = 0;

    always #5 clk = ~clk;

    sspirq_top i_sspirq_top (
        .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .tx_level(tx_level),
        .frame_done(frame_done), .rx_pop(rx_pop), .prescale(prescale),
        .scr(scr), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [3:0]  exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd(2'd0, d); chk("R1 mask", d, 0);
        rd(2'd2, d); chk("R1 masked", d, 0);
        rd(2'd1, d); chk("R1 raw", d, 32'h8);
        chk("R1 irq", {31'b0, irq}, 0);

        // R5 R6 R9 R10: sweep levels and masks
        for (int rl = 0; rl <= 8; rl++) begin
            for (int tl = 0; tl <= 8; tl++) begin
                rx_level = 4'(rl); tx_level = 4'(tl);
                exp = {(tl <= 4), (rl >= 4), 2'b00};
                rd(2'd1, d); chk("R5 raw", d, {28'b0, exp});
                for (int m = 0; m < 16; m++) begin
                    @(negedge clk);
                    wr(2'd0, 32'hFFFF_FFF0 | 32'(m));
                    rd(2'd0, d); chk("R10 mask read", d, 32'(m));
                    rd(2'd2, d); chk("R6 masked", d, {28'b0, exp & 4'(m)});
                    @(negedge clk);
                    chk("R9 irq", {31'b0, irq}, {31'b0, |(exp & 4'(m))});
                end
            end
        end
        wr(2'd0, 32'h0);

        // R2: overrun only at full
        rx_level = 4'd7; tx_level = 4'd0;
        frame_done = 1'b1; @(negedge clk); frame_done = 1'b0;
        rd(2'd1, d); chk("R2 no set at 7", {31'b0, d[0]}, 0);
        rx_level = 4'd8;
        frame_done = 1'b1; @(negedge clk); frame_done = 1'b0;
        rd(2'd1, d); chk("R2 set at full", {31'b0, d[0]}, 1);
        repeat (5) @(negedge clk);
        rd(2'd1, d); chk("R2 sticky", {31'b0, d[0]}, 1);

        // R7: clear register behaviour
        wr(2'd3, 32'h0);
        rd(2'd1, d); chk("R7 zero write", d, 32'hD);
        wr(2'd3, 32'hC);
        rd(2'd1, d); chk("R7 level bits untouched", d, 32'hD);
        rd(2'd3, d); chk("R7 clr reads 0", d, 0);
        wr(2'd3, 32'h1);
        rd(2'd1, d); chk("R7 ovr cleared", {31'b0, d[0]}, 0);

        // R8: set and clear on one edge
        frame_done = 1'b1;
        wr(2'd3, 32'h1);
        frame_done = 1'b0;
        rd(2'd1, d); chk("R8 set wins", {31'b0, d[0]}, 1);
        wr(2'd3, 32'h1);

        // R9: irq lags the masked source by one register
        wr(2'd0, 32'h1);
        frame_done = 1'b1; @(negedge clk); frame_done = 1'b0;
        chk("R9 irq lag", {31'b0, irq}, 0);
        @(negedge clk);
        chk("R9 irq up", {31'b0, irq}, 1);
        wr(2'd3, 32'h1);
        chk("R9 irq lag drop", {31'b0, irq}, 1);
        @(negedge clk);
        chk("R9 irq down", {31'b0, irq}, 0);
        wr(2'd0, 32'h0);

        // R3: timeout timing grid
        for (int p = 0; p <= 3; p++) begin
            for (int s = 0; s <= 2; s++) begin
                int n;
                n = 32 * ((p == 0) ? 1 : p) * (s + 1);
                rx_level = 4'd0; prescale = 8'(p); scr = 8'(s);
                @(negedge clk);
                wr(2'd3, 32'h2);
                rx_level = 4'd1; frame_done = 1'b1;
                @(negedge clk); frame_done = 1'b0;
                repeat (n - 1) @(negedge clk);
                rd(2'd1, d); chk("R3 not yet", {31'b0, d[1]}, 0);
                @(negedge clk);
                rd(2'd1, d); chk("R3 expired", {31'b0, d[1]}, 1);
            end
        end

        // R4: read restarts the count
        rx_level = 4'd0; prescale = 8'd1; scr = 8'd0;
        @(negedge clk);
        wr(2'd3, 32'h2);
        rx_level = 4'd2; frame_done = 1'b1;
        @(negedge clk); frame_done = 1'b0;
        repeat (20) @(negedge clk);
        rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0;
        repeat (31) @(negedge clk);
        rd(2'd1, d); chk("R4 pop restart", {31'b0, d[1]}, 0);
        @(negedge clk);
        rd(2'd1, d); chk("R4 pop expire", {31'b0, d[1]}, 1);

        // R4: empty FIFO holds the count at zero
        rx_level = 4'd0;
        wr(2'd3, 32'h2);
        repeat (100) @(negedge clk);
        rd(2'd1, d); chk("R4 empty hold", {31'b0, d[1]}, 0);
        rx_level = 4'd1;
        repeat (31) @(negedge clk);
        rd(2'd1, d); chk("R4 empty restart", {31'b0, d[1]}, 0);
        @(negedge clk);
        rd(2'd1, d); chk("R4 empty expire", {31'b0, d[1]}, 1);
        wr(2'd3, 32'h2);
        rd(2'd1, d); chk("R7 to cleared", {31'b0, d[1]}, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule